// File: doc/BRIEF.md
# Two-Dimensional Indexed Load/Store Unit

This block carries out the memory half of a load or store instruction on a machine whose 18-bit words double as two-dimensional coordinates. The upper nine bits of a word hold the y ordinate and the lower nine bits hold the x ordinate. Each request brings an access kind, a masking mode, an ALU code and two register operands. From these the unit forms the memory address. The masking mode controls only how that address is formed. It never changes how many bits move.

The unit drives a word-wide synchronous memory, where read data is valid in the cycle after a read strobe. Loads return the fetched word to the register file, with a two-bit write-enable that selects the halves to update. Stores take their data from the register named in the target field. A store of only one half is carried out as a read-modify-write of the addressed word, so the other half of that word is kept. Every request takes five cycles in total. The unit holds one request at a time.

Top module: `ldst_unit`

## Requirements
- R1: A whole-word load (reqOp 001) returns all 18 bits of the addressed word on rfWrData, with rfWrHalf = 11, in every masking mode.
- R2: An x-half load (reqOp 010) asserts only rfWrHalf bit 0 (bits 8..0), and a y-half load (reqOp 011) asserts only rfWrHalf bit 1 (bits 17..9). rfWrData carries the addressed word.
- R3: A whole-word store (reqOp 100) writes srcData to the computed address and does no memory read.
- R4: A half store runs as read-modify-write. It reads the addressed word, then writes it back to the same address with one half replaced by srcData: the x half for reqOp 101, the y half for reqOp 110. Read data is taken one cycle after memRdEn.
- R5: In vector mode (reqMode 00) the ALU code is applied to each ordinate on its own, and no carry or borrow crosses bit 9.
- R6: In scalar mode (reqMode 11) the ALU code is applied to the full 18-bit word, so carries cross the halves.
- R7: In X mode (reqMode 01) the address takes its x half from the x-ordinate operation and its y half is zero. In Y mode (reqMode 10) it takes its y half from the y-ordinate operation and its x half is zero.
- R8: ALU codes are 000 add, 001 subtract (A minus B), 010 AND, 011 OR and 100 XOR. Codes 101 to 111 pass operand A through unchanged.
- R9: A request accepted at a clock edge raises busy for the next four cycles. The fourth of those cycles carries the one-cycle done pulse, together with the memory write or register write-back.
- R10: A request is ignored while busy is high, and the latched operands are kept. A request with reqOp 000 or 111 is never accepted.
- R11: After reset, busy, done, memRdEn, memWrEn, rfWrEn and rfWrHalf are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 3 | Access kind (001..110) |
| reqMode | input | 2 | Masking mode for the address |
| reqAluOp | input | 3 | Address operation code |
| opA | input | 18 | Left address operand |
| opB | input | 18 | Right address operand |
| srcData | input | 18 | Target register value (store data) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | 18 | Memory address {y, x} |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 18 | Memory write data |
| memRdData | input | 18 | Memory read data, one cycle after memRdEn |
| rfWrEn | output | 1 | Register write strobe |
| rfWrHalf | output | 2 | Half enables: bit 0 x half, bit 1 y half |
| rfWrData | output | 18 | Register write data |

## Verification
The request is driven on a falling edge and accepted on the next rising edge. The bench then samples on the four following falling edges. busy must be high on each of them, done must be low on the first three, memAddr and memRdEn must be valid on the second, and done must be high on the fourth. That fourth sample is also where memory write data, rfWrData and rfWrHalf are compared against values the bench computes itself. The fifth sample must find the unit idle, and a request injected mid-operation must leave it idle one cycle later.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    MASK_VEC    = 2'b00,
    MASK_X      = 2'b01,
    MASK_Y      = 2'b10,
    MASK_SCALAR = 2'b11
  } mask_mode_e;

  localparam logic [2:0] OP_LDW = 3'b001;
  localparam logic [2:0] OP_LDX = 3'b010;
  localparam logic [2:0] OP_LDY = 3'b011;
  localparam logic [2:0] OP_STW = 3'b100;
  localparam logic [2:0] OP_STX = 3'b101;
  localparam logic [2:0] OP_STY = 3'b110;

  localparam logic [2:0] ALU_ADD = 3'b000;
  localparam logic [2:0] ALU_SUB = 3'b001;
  localparam logic [2:0] ALU_AND = 3'b010;
  localparam logic [2:0] ALU_OR  = 3'b011;
  localparam logic [2:0] ALU_XOR = 3'b100;

  // strobes from control to datapath
  typedef struct packed {
    logic [2:0] op;
    logic       latchReq;
    logic       latchAddr;
    logic       memRead;
    logic       captureRd;
    logic       finish;
  } ldst_strobe_t;

endpackage

// File: rtl/ldst_alu_slice.sv
module ldst_alu_slice #(
  parameter int W = 9
) (
  input  logic [2:0]   aluOp,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  import ldst_pkg::*;

  always_comb begin
    case (aluOp)
      ALU_ADD: res = lhs + rhs;
      ALU_SUB: res = lhs - rhs;
      ALU_AND: res = lhs & rhs;
      ALU_OR:  res = lhs | rhs;
      ALU_XOR: res = lhs ^ rhs;
      default: res = lhs;
    endcase
  end
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
  parameter int HALF_W = 9,
  localparam int WORD_W = 2 * HALF_W
) (
  input  ldst_pkg::mask_mode_e mode,
  input  logic [2:0]           aluOp,
  input  logic [WORD_W-1:0]    opA,
  input  logic [WORD_W-1:0]    opB,
  output logic [WORD_W-1:0]    addr
);
  import ldst_pkg::*;

  logic [1:0][HALF_W-1:0] halfRes;  // [0] x ordinate, [1] y ordinate
  logic [WORD_W-1:0]      wordRes;

  for (genvar h = 0; h < 2; h++) begin : g_half
    ldst_alu_slice #(.W(HALF_W)) slice_i (
      .aluOp(aluOp),
      .lhs  (opA[h*HALF_W +: HALF_W]),
      .rhs  (opB[h*HALF_W +: HALF_W]),
      .res  (halfRes[h])
    );
  end

  ldst_alu_slice #(.W(WORD_W)) word_i (
    .aluOp(aluOp),
    .lhs  (opA),
    .rhs  (opB),
    .res  (wordRes)
  );

  always_comb begin
    case (mode)
      MASK_SCALAR: addr = wordRes;
      MASK_X:      addr = {{HALF_W{1'b0}}, halfRes[0]};
      MASK_Y:      addr = {halfRes[1], {HALF_W{1'b0}}};
      default:     addr = {halfRes[1], halfRes[0]};
    endcase
  end
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [2:0]             reqOp,
  output ldst_pkg::ldst_strobe_t strb,
  output logic                   busy,
  output logic                   done
);
  import ldst_pkg::*;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CALC, ST_READ, ST_MERGE, ST_FINISH
  } ctrl_state_e;

  ctrl_state_e state;
  logic [2:0]  opReg;
  logic        opValid;
  logic        accept;

  assign opValid = (reqOp != 3'b000) && (reqOp != 3'b111);
  assign accept  = (state == ST_IDLE) && reqValid && opValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= '0;
    end else begin
      case (state)
        ST_IDLE:   if (accept) begin
                     state <= ST_CALC;
                     opReg <= reqOp;
                   end
        ST_CALC:   state <= ST_READ;
        ST_READ:   state <= ST_MERGE;
        ST_MERGE:  state <= ST_FINISH;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.op        = opReg;
    strb.latchReq  = accept;
    strb.latchAddr = (state == ST_CALC);
    strb.memRead   = (state == ST_READ) && (opReg != OP_STW);
    strb.captureRd = (state == ST_MERGE);
    strb.finish    = (state == ST_FINISH);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);
endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath #(
  parameter int HALF_W = 9,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ldst_pkg::ldst_strobe_t strb,
  input  logic [1:0]             reqMode,
  input  logic [2:0]             reqAluOp,
  input  logic [WORD_W-1:0]      opA,
  input  logic [WORD_W-1:0]      opB,
  input  logic [WORD_W-1:0]      srcData,
  input  logic [WORD_W-1:0]      memRdData,
  output logic [WORD_W-1:0]      memAddr,
  output logic                   memRdEn,
  output logic                   memWrEn,
  output logic [WORD_W-1:0]      memWrData,
  output logic                   rfWrEn,
  output logic [1:0]             rfWrHalf,
  output logic [WORD_W-1:0]      rfWrData
);
  import ldst_pkg::*;

  mask_mode_e        modeReg;
  logic [2:0]        aluReg;
  logic [WORD_W-1:0] aReg, bReg, srcReg;
  logic [WORD_W-1:0] addrReg, dataReg;
  logic [WORD_W-1:0] addrNext, mergeWord;
  logic [1:0]        halfSel;

  ldst_addr_gen #(.HALF_W(HALF_W)) addr_i (
    .mode (modeReg),
    .aluOp(aluReg),
    .opA  (aReg),
    .opB  (bReg),
    .addr (addrNext)
  );

  // word that ends up in dataReg once memory data is in hand
  always_comb begin
    case (strb.op)
      OP_STW:  mergeWord = srcReg;
      OP_STX:  mergeWord = {memRdData[WORD_W-1:HALF_W], srcReg[HALF_W-1:0]};
      OP_STY:  mergeWord = {srcReg[WORD_W-1:HALF_W], memRdData[HALF_W-1:0]};
      default: mergeWord = memRdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MASK_VEC;
      aluReg  <= '0;
      aReg    <= '0;
      bReg    <= '0;
      srcReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strb.latchReq) begin
        modeReg <= mask_mode_e'(reqMode);
        aluReg  <= reqAluOp;
        aReg    <= opA;
        bReg    <= opB;
        srcReg  <= srcData;
      end
      if (strb.latchAddr) addrReg <= addrNext;
      if (strb.captureRd) dataReg <= mergeWord;
    end
  end

  always_comb begin
    case (strb.op)
      OP_LDX:  halfSel = 2'b01;
      OP_LDY:  halfSel = 2'b10;
      default: halfSel = 2'b11;
    endcase
  end

  assign memAddr   = addrReg;
  assign memRdEn   = strb.memRead;
  assign memWrEn   = strb.finish && strb.op[2];
  assign memWrData = dataReg;
  assign rfWrEn    = strb.finish && !strb.op[2];
  assign rfWrHalf  = rfWrEn ? halfSel : 2'b00;
  assign rfWrData  = dataReg;
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit #(
  parameter int HALF_W = 9,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [1:0]        reqMode,
  input  logic [2:0]        reqAluOp,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] srcData,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData,
  output logic              rfWrEn,
  output logic [1:0]        rfWrHalf,
  output logic [WORD_W-1:0] rfWrData
);
  import ldst_pkg::*;

  ldst_strobe_t strb;

  ldst_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  ldst_datapath #(.HALF_W(HALF_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqMode  (reqMode),
    .reqAluOp (reqAluOp),
    .opA      (opA),
    .opB      (opB),
    .srcData  (srcData),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memRdEn  (memRdEn),
    .memWrEn  (memWrEn),
    .memWrData(memWrData),
    .rfWrEn   (rfWrEn),
    .rfWrHalf (rfWrHalf),
    .rfWrData (rfWrData)
  );
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
  parameter int HALF_W = 9,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] memAddr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic              rfWrEn,
  input logic [1:0]        rfWrHalf
);
  logic accept;
  assign accept = reqValid && !busy && (reqOp != 3'b000) && (reqOp != 3'b111);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);

  p_done_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(accept, 4));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && (reqOp == 3'b000 || reqOp == 3'b111)) |=> !busy);

  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  p_rmw_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> $stable(memAddr));

  p_store_at_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> done);

  p_load_wb_r1: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (done && !memWrEn));

  p_half_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (rfWrHalf != 2'b00));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !memWrEn && !rfWrEn));
endmodule

bind ldst_unit ldst_unit_chk #(.HALF_W(HALF_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqOp   (reqOp),
  .busy    (busy),
  .done    (done),
  .memAddr (memAddr),
  .memRdEn (memRdEn),
  .memWrEn (memWrEn),
  .rfWrEn  (rfWrEn),
  .rfWrHalf(rfWrHalf)
);

// File: tb/ldst_unit_tb_top.sv
module ldst_unit_tb_top;
  localparam int HW = 9;
  localparam int WW = 2 * HW;
  localparam int NVEC = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqOp = '0;
  logic [1:0]    reqMode = '0;
  logic [2:0]    reqAluOp = '0;
  logic [WW-1:0] opA = '0, opB = '0, srcData = '0;
  logic          busy, done, memRdEn, memWrEn, rfWrEn;
  logic [WW-1:0] memAddr, memWrData, rfWrData;
  logic [WW-1:0] memRdData = '0;
  logic [1:0]    rfWrHalf;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;

  always #4 clk = ~clk;

  ldst_unit #(.HALF_W(HW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqMode(reqMode), .reqAluOp(reqAluOp), .opA(opA), .opB(opB),
    .srcData(srcData), .busy(busy), .done(done), .memAddr(memAddr),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData), .rfWrEn(rfWrEn), .rfWrHalf(rfWrHalf),
    .rfWrData(rfWrData)
  );

  // sparse memory model; unwritten words read as a pattern of the address
  logic [WW-1:0] memStore [int];

  function automatic logic [WW-1:0] modelRead(input logic [WW-1:0] a);
    if (memStore.exists(int'(a))) return memStore[int'(a)];
    return a ^ 18'o525252;
  endfunction

  always @(posedge clk) begin
    if (memWrEn) memStore[int'(memAddr)] = memWrData;
    if (memRdEn) memRdData <= modelRead(memAddr);
  end

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 50000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycleCount);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%o expected=%o", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] aluRef(input logic [2:0] f,
                                           input logic [WW-1:0] x, input logic [WW-1:0] y);
    case (f)
      3'b000:  return x + y;
      3'b001:  return x - y;
      3'b010:  return x & y;
      3'b011:  return x | y;
      3'b100:  return x ^ y;
      default: return x;
    endcase
  endfunction

  function automatic logic [WW-1:0] addrRef(input logic [1:0] m, input logic [2:0] f,
                                            input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [WW-1:0] lo, hi;
    lo = aluRef(f, {9'b0, a[8:0]}, {9'b0, b[8:0]});
    hi = aluRef(f, {9'b0, a[17:9]}, {9'b0, b[17:9]});
    case (m)
      2'b11:   return aluRef(f, a, b);
      2'b01:   return {9'b0, lo[8:0]};
      2'b10:   return {hi[8:0], 9'b0};
      default: return {hi[8:0], lo[8:0]};
    endcase
  endfunction

  task automatic doOp(input logic [2:0] op, input logic [1:0] m, input logic [2:0] f,
                      input logic [WW-1:0] a, input logic [WW-1:0] b,
                      input logic [WW-1:0] src, input bit inject);
    logic [WW-1:0] expAddr, oldWord, expWord;
    logic [1:0] expHalf;
    string modeTag, dataTag;
    expAddr = addrRef(m, f, a, b);
    oldWord = modelRead(expAddr);
    case (m)
      2'b00:   modeTag = "R5 R8 vector address";
      2'b11:   modeTag = "R6 R8 scalar address";
      default: modeTag = "R7 R8 masked address";
    endcase
    case (op)
      3'b100:  expWord = src;
      3'b101:  expWord = {oldWord[17:9], src[8:0]};
      3'b110:  expWord = {src[17:9], oldWord[8:0]};
      default: expWord = oldWord;
    endcase
    expHalf = (op == 3'b010) ? 2'b01 : (op == 3'b011) ? 2'b10 : 2'b11;
    if (op == 3'b001) dataTag = "R1 whole load";
    else if (op[2] == 1'b0) dataTag = "R2 half load";
    else if (op == 3'b100) dataTag = "R3 whole store";
    else dataTag = "R4 half store merge";

    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqMode = m; reqAluOp = f;
    opA = a; opB = b; srcData = src;
    @(negedge clk);  // cycle 1
    reqValid = 1'b0;
    check(busy && !done, "R9 busy cycle 1", {busy, done}, 2'b10);
    @(negedge clk);  // cycle 2: address and read strobe visible
    check(busy && !done, "R9 busy cycle 2", {busy, done}, 2'b10);
    check(memAddr == expAddr, modeTag, memAddr, expAddr);
    check(memRdEn == (op != 3'b100), "R4 R3 read strobe", memRdEn, (op != 3'b100));
    if (inject) begin
      reqValid = 1'b1; reqOp = 3'b100; reqMode = 2'b11; reqAluOp = 3'b000;
      opA = 18'o000777; opB = 18'o000001; srcData = 18'o777777;
    end
    @(negedge clk);  // cycle 3
    reqValid = 1'b0;
    check(busy && !done, "R9 busy cycle 3", {busy, done}, 2'b10);
    @(negedge clk);  // cycle 4: completion
    check(done && busy, "R9 done cycle 4", {busy, done}, 2'b11);
    if (op[2]) begin
      check(memWrEn && !rfWrEn, {dataTag, " strobes"}, {memWrEn, rfWrEn}, 2'b10);
      check(memAddr == expAddr, {dataTag, " address"}, memAddr, expAddr);
      check(memWrData == expWord, dataTag, memWrData, expWord);
    end else begin
      check(rfWrEn && !memWrEn, {dataTag, " strobes"}, {rfWrEn, memWrEn}, 2'b10);
      check(rfWrHalf == expHalf, {dataTag, " half enables"}, rfWrHalf, expHalf);
      check(rfWrData == expWord, dataTag, rfWrData, expWord);
    end
    @(negedge clk);  // cycle 5
    check(!busy && !done, "R9 idle after done", {busy, done}, 2'b00);
    if (inject) begin
      @(negedge clk);
      check(!busy, "R10 request while busy ignored", busy, 1'b0);
    end
  endtask

  // {op, mode, alu, a, b, src}
  localparam logic [61:0] VEC_TABLE [NVEC] = '{
    {3'b001, 2'b00, 3'b000, 18'o115333, 18'o225511, 18'o000000},
    {3'b001, 2'b11, 3'b000, 18'o115333, 18'o225511, 18'o000000},
    {3'b010, 2'b01, 3'b001, 18'o123456, 18'o001002, 18'o000000},
    {3'b011, 2'b10, 3'b100, 18'o707070, 18'o070707, 18'o000000},
    {3'b100, 2'b00, 3'b010, 18'o777123, 18'o070777, 18'o246135},
    {3'b101, 2'b11, 3'b011, 18'o000400, 18'o000077, 18'o111222},
    {3'b110, 2'b01, 3'b000, 18'o500010, 18'o000020, 18'o333444},
    {3'b001, 2'b00, 3'b101, 18'o012345, 18'o777777, 18'o000000},
    {3'b001, 2'b10, 3'b001, 18'o000000, 18'o001000, 18'o000000},
    {3'b001, 2'b00, 3'b011, 18'o000400, 18'o000077, 18'o000000},
    {3'b001, 2'b01, 3'b000, 18'o500010, 18'o000020, 18'o000000}
  };

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk);
    check({busy, done, memRdEn, memWrEn, rfWrEn, rfWrHalf} == 7'b0,
          "R11 reset outputs", {busy, done, memRdEn, memWrEn, rfWrEn, rfWrHalf}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy, "R11 idle after reset", busy, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [61:0] e;
      e = VEC_TABLE[i];
      doOp(e[61:59], e[58:57], e[56:54], e[53:36], e[35:18], e[17:0], 1'b0);
    end

    // R4 y-half store over a written word, then read back both halves intact
    doOp(3'b110, 2'b00, 3'b000, 18'o000400, 18'o000077, 18'o654321, 1'b0);
    doOp(3'b010, 2'b00, 3'b000, 18'o000400, 18'o000077, 18'o000000, 1'b0);
    // R1 whole load in Y mode still returns all bits
    doOp(3'b001, 2'b10, 3'b000, 18'o300000, 18'o077000, 18'o000000, 1'b0);

    // R10 request while busy is dropped and operands stay latched
    doOp(3'b001, 2'b00, 3'b000, 18'o010010, 18'o001001, 18'o000000, 1'b1);

    // R10 invalid kinds never start
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqOp = (k == 0) ? 3'b000 : 3'b111;
      @(negedge clk);
      reqValid = 1'b0;
      check(!busy, "R10 invalid op ignored", busy, 1'b0);
      @(negedge clk);
      check(!busy && !memWrEn && !rfWrEn, "R10 invalid op no access",
            {busy, memWrEn, rfWrEn}, 3'b000);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule